// File: doc/BRIEF.md
# ATA Host Interrupt Status, Mask and Reset-Pulse Register

This block holds the interrupt state of an ATA host controller. Eight event lines each set a sticky status bit. Software clears a status bit by writing a one to it. The upper byte of the same 16-bit register holds one mask bit per source. A registered interrupt line is high while any status bit is set and its mask bit is clear.

A side-effect strobe comes from the bus-master DMA status register. When it carries the interrupt-acknowledge bit, it clears the host and transfer-end status bits and empties the whole mask byte. Software then has to restore its masks.

A second register, the system-control register, starts timed pulses. One is a soft reset, which zeroes status and mask for as long as it lasts. The other is a data-FIFO reset, which is the recovery step after a bus error. Reading the system-control register returns whether each pulse is still running, together with a cable-type input.

Top module: `ata_irq_ctl`

## Requirements
- R1: After the reset input, the status byte is zero, the mask byte equals RST_MASK (default 0xFA), and irq_out, soft_rst_out and fifo_rst_out are low. The interrupt register (reg_sel=0) reads mask in bits 15:8 and status in bits 7:0.
- R2: A high event_in[i] sets status bit i at the clock edge, and the bit stays set after the event goes away. The status bits are assigned as follows:
  - bit 0: host (device) interrupt
  - bit 1: transfer end
  - bit 2: bus error
  - bit 3: timer
  - bit 4: UDMA terminate
  - bit 5: device timing error
  - bit 6: reached multiple
  - bit 7: address error
- R3: A write to the interrupt register clears every status bit whose write-data bit in 7:0 is 1. Bits written 0 keep their value. The same write loads bits 15:8 into the mask byte.
- R4: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: irq_out equals the OR over all bits of (status AND NOT mask), taken one clock after the status and mask values it reflects.
- R6: A dma_stat_wr pulse with dma_stat_wdata bit 2 set clears status bits 1 and 0 and all eight mask bits. With bit 2 clear, the pulse has no effect.
- R7: A write to the system-control register (reg_sel=1) with bit 15 set drives soft_rst_out high for exactly SRST_CYCLES cycles (default 20), starting the cycle after the write. While soft_rst_out is high, status and mask are forced to zero and events are ignored.
- R8: A system-control write with bit 14 set drives fifo_rst_out high for exactly FRST_CYCLES cycles (default 12), starting the cycle after the write.
- R9: Reading the system-control register returns the following, with all other bits 0:
  - bit 15: soft_rst_out
  - bit 14: fifo_rst_out
  - bit 13: cable_40 (1 = 40-conductor cable, 0 = 80-conductor cable)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = interrupt register, 1 = system-control register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| event_in | input | 8 | Interrupt event lines |
| dma_stat_wr | input | 1 | Write strobe from the DMA status register |
| dma_stat_wdata | input | 8 | Data of that DMA status write |
| cable_40 | input | 1 | Cable-type sense |
| irq_out | output | 1 | Registered interrupt request |
| soft_rst_out | output | 1 | Soft-reset pulse |
| fifo_rst_out | output | 1 | FIFO-reset pulse |

## Verification
A status bit that is lost or stuck shows up on reg_rdata at the very next read. It shows up on irq_out one clock later, but only if its mask bit is clear. That is why the bench unmasks sources before it checks latency. A wrong pulse counter shows up only as a pulse that is too short or too long, so both pulse lengths are measured cycle by cycle. The data-loss cases are the side-effect DMA clear and a set arriving together with a clear. The bench checks each of them on the register in the cycle right after it happens.

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl #(
  parameter int SRST_CYCLES = 20,
  parameter int FRST_CYCLES = 12,
  parameter logic [7:0] RST_MASK = 8'hFA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [7:0]  event_in,
  input  logic        dma_stat_wr,
  input  logic [7:0]  dma_stat_wdata,
  input  logic        cable_40,
  output logic        irq_out,
  output logic        soft_rst_out,
  output logic        fifo_rst_out
);
  localparam int SW = $clog2(SRST_CYCLES + 1);
  localparam int FW = $clog2(FRST_CYCLES + 1);
  localparam logic [7:0] DMA_CLR_BITS = 8'h03;

  logic [7:0]    status_q, mask_q;
  logic [SW-1:0] srst_cnt;
  logic [FW-1:0] frst_cnt;

  wire int_wr  = reg_wr_en && !reg_sel;
  wire sys_wr  = reg_wr_en && reg_sel;
  wire dma_clr = dma_stat_wr && dma_stat_wdata[2];

  assign soft_rst_out = srst_cnt != '0;
  assign fifo_rst_out = frst_cnt != '0;

  wire [7:0] w1c_bits = int_wr ? reg_wdata[7:0] : 8'h00;
  wire [7:0] dma_bits = dma_clr ? DMA_CLR_BITS : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= RST_MASK;
      irq_out  <= 1'b0;
    end else begin
      irq_out <= |(status_q & ~mask_q);
      if (soft_rst_out) begin
        status_q <= '0;
        mask_q   <= '0;
      end else begin
        status_q <= (status_q & ~w1c_bits & ~dma_bits) | event_in;
        if (dma_clr)     mask_q <= '0;
        else if (int_wr) mask_q <= reg_wdata[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_cnt <= '0;
      frst_cnt <= '0;
    end else begin
      if (sys_wr && reg_wdata[15]) srst_cnt <= SW'(SRST_CYCLES);
      else if (soft_rst_out)       srst_cnt <= srst_cnt - 1'b1;
      if (sys_wr && reg_wdata[14]) frst_cnt <= FW'(FRST_CYCLES);
      else if (fifo_rst_out)       frst_cnt <= frst_cnt - 1'b1;
    end
  end

  assign reg_rdata = reg_sel ? {soft_rst_out, fifo_rst_out, cable_40, 13'b0}
                             : {mask_q, status_q};
endmodule

// File: rtl/ata_irq_ctl_chk.sv
module ata_irq_ctl_chk #(
  parameter int SRST_CYCLES = 20,
  parameter int FRST_CYCLES = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] event_in,
  input logic       dma_stat_wr,
  input logic [7:0] dma_stat_wdata,
  input logic       irq_out,
  input logic       soft_rst_out,
  input logic       fifo_rst_out,
  input logic [7:0] status_q,
  input logic [7:0] mask_q
);
  int s_len, f_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_len <= 0;
      f_len <= 0;
    end else begin
      s_len <= soft_rst_out ? s_len + 1 : 0;
      f_len <= fifo_rst_out ? f_len + 1 : 0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_out |=> ((status_q & $past(event_in)) == $past(event_in))); // R4

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(status_q & ~mask_q))); // R5

  AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_stat_wr && dma_stat_wdata[2] && !soft_rst_out)
      |=> (mask_q == 8'h00 && status_q[1:0] == $past(event_in[1:0]))); // R6

  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_out |=> (status_q == 8'h00 && mask_q == 8'h00)); // R7

  AST_SRST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_out) |-> s_len == SRST_CYCLES); // R7

  AST_FRST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_rst_out) |-> f_len == FRST_CYCLES); // R8
endmodule

bind ata_irq_ctl ata_irq_ctl_chk #(
  .SRST_CYCLES(SRST_CYCLES),
  .FRST_CYCLES(FRST_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .event_in(event_in),
  .dma_stat_wr(dma_stat_wr), .dma_stat_wdata(dma_stat_wdata),
  .irq_out(irq_out), .soft_rst_out(soft_rst_out), .fifo_rst_out(fifo_rst_out),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/tb_ata_irq_ctl.sv
`timescale 1ns/10ps
module tb_ata_irq_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [7:0] event_in = '0, dma_stat_wdata = '0;
  logic dma_stat_wr = 1'b0, cable_40 = 1'b1;
  logic irq_out, soft_rst_out, fifo_rst_out;

  ata_irq_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
    .dma_stat_wr(dma_stat_wr), .dma_stat_wdata(dma_stat_wdata),
    .cable_40(cable_40), .irq_out(irq_out),
    .soft_rst_out(soft_rst_out), .fifo_rst_out(fifo_rst_out)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    string       req;
    int          which;
    logic [15:0] exp;
    logic [15:0] meas;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  initial begin : monitor
    forever begin
      item_t it;
      logic [15:0] act;
      wait (q.size() != 0);
      #0.1;
      it = q.pop_front();
      case (it.which)
        0, 1:    act = reg_rdata;
        2:       act = {15'b0, irq_out};
        default: act = it.meas;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_val(string req, int which, logic [15:0] exp, logic [15:0] meas = '0);
    item_t it;
    if (which < 2) reg_sel = which[0];
    it.req = req; it.which = which; it.exp = exp; it.meas = meas;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic dma(logic [7:0] d);
    dma_stat_wr = 1'b1; dma_stat_wdata = d;
    tick();
    dma_stat_wr = 1'b0;
  endtask

  task automatic pulse_ev(logic [7:0] e);
    event_in = e;
    tick();
    event_in = '0;
  endtask

  initial begin : watchdog
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_val("R1 reset int reg", 0, 16'hFA00);
    expect_val("R1 reset irq", 2, 16'h0000);
    expect_val("R9 cable 40", 1, 16'h2000);

    pulse_ev(8'h04);
    expect_val("R2 bus error sticky", 0, 16'hFA04);
    expect_val("R5 irq not yet", 2, 16'h0000);
    tick();
    expect_val("R5 irq after one clock", 2, 16'h0001);

    wr(1'b0, 16'hFA04);
    expect_val("R3 w1c clears", 0, 16'hFA00);
    tick();
    expect_val("R5 irq drops", 2, 16'h0000);

    pulse_ev(8'h80);
    tick();
    expect_val("R5 masked source no irq", 2, 16'h0000);
    wr(1'b0, 16'hFA00);
    expect_val("R3 zero write keeps", 0, 16'hFA80);

    event_in = 8'h80;
    wr(1'b0, 16'hFA80);
    event_in = '0;
    expect_val("R4 set beats clear", 0, 16'hFA80);
    wr(1'b0, 16'hFA80);
    expect_val("R3 clear bit7", 0, 16'hFA00);

    wr(1'b0, 16'h7F00);
    expect_val("R3 mask load", 0, 16'h7F00);
    pulse_ev(8'h80);
    expect_val("R5 unmasked irq low", 2, 16'h0000);
    tick();
    expect_val("R5 unmasked irq high", 2, 16'h0001);

    pulse_ev(8'h0B);
    dma(8'h04);
    expect_val("R6 dma clears bits1:0 and mask", 0, 16'h0088);
    tick();
    expect_val("R6 irq after mask wipe", 2, 16'h0001);

    wr(1'b0, 16'hFA88);
    pulse_ev(8'h03);
    dma(8'hFB);
    expect_val("R6 no bit2 no effect", 0, 16'hFA03);
    dma(8'h04);
    expect_val("R6 second clear", 0, 16'h0000);

    wr(1'b1, 16'h8000);
    expect_val("R9 soft active read", 1, 16'hA000);
    n = 0;
    event_in = 8'hFF;
    repeat (3) begin
      if (soft_rst_out) n++;
      tick();
    end
    event_in = '0;
    expect_val("R7 held zero", 0, 16'h0000);
    while (soft_rst_out && n < 100) begin
      n++;
      tick();
    end
    expect_val("R7 soft pulse length", 3, 16'd20, n[15:0]);
    expect_val("R7 after soft reset", 0, 16'h0000);
    expect_val("R9 soft done", 1, 16'h2000);

    wr(1'b1, 16'h4000);
    expect_val("R9 fifo active read", 1, 16'h6000);
    n = 0;
    while (fifo_rst_out && n < 100) begin
      n++;
      tick();
    end
    expect_val("R8 fifo pulse length", 3, 16'd12, n[15:0]);

    cable_40 = 1'b0;
    expect_val("R9 cable 80", 1, 16'h0000);

    tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule